// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner

This block takes three BCD digits (units, tens and hundreds) and presents them one at a time on a single shared four-bit bus. Three active-low select lines tell an external display which digit the bus is carrying. A single-cycle scan tick moves the scanner on by one position. The tick stands in for a slow scan oscillator. The rotation runs units, then tens, then hundreds, and then back to units.

A synchronous master reset input parks the scanner on the units position and holds all selects inactive, which blanks the display. While it is high, ticks are ignored. When it is released, the next clock edge turns the units select on again, and scanning resumes from there. The chip-level asynchronous reset leaves the block in the same parked and blanked state.

The bus and the selects both come from one registered position, so they always change on the same clock edge. The digit inputs are muxed straight through, so a change on the selected digit shows on the bus in the same cycle.

Top module: `bcd_digit_scanner`

## Requirements
- R1: While rst_n is low, and until the first clock edge after it rises, sel_n_o is 3'b111 and bcd_o equals the units digit, digits_i[3:0].
- R2: On the clock edge after an edge that sees mreset_i high, sel_n_o is 3'b111. The selects stay blanked for as long as mreset_i remains high.
- R3: An edge that sees mreset_i high parks the scanner on units. The first edge that sees mreset_i low then gives sel_n_o = 3'b110.
- R4: Each edge that sees scan_tick_i high and mreset_i low advances the position by one, in the order units (sel_n_o[0] low), tens (sel_n_o[1] low), hundreds (sel_n_o[2] low), and back to units.
- R5: An edge that sees scan_tick_i low and mreset_i low leaves the position and sel_n_o unchanged.
- R6: scan_tick_i has no effect while mreset_i is high. After release, the first select shown is units no matter how many ticks arrived during reset.
- R7: Outside the blanked state, exactly one bit of sel_n_o is low.
- R8: bcd_o (active high) always equals the digit at the current position: units digits_i[3:0], tens digits_i[7:4], hundreds digits_i[11:8]. A change on digits_i reaches bcd_o in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset_i | input | 1 | Synchronous active-high master reset: park and blank |
| scan_tick_i | input | 1 | Single-cycle pulse that advances the scanner |
| digits_i | input | 12 | Three BCD digits, with units in the low nibble |
| bcd_o | output | 4 | Shared active-high BCD bus |
| sel_n_o | output | 3 | Active-low digit selects: bit 0 units, bit 2 hundreds |

## Verification
Directed sequences come first:
- a run of ticks shows the full rotation order and the wrap from hundreds back to units;
- idle cycles separate holding from advancing;
- ticks applied during master reset show that the parked position ignores them;
- a digit change in mid-cycle separates a combinational bus from a registered one.

Random traffic then mixes ticks, occasional master resets and random BCD digits. At every cycle the bus and selects are compared with a reference model of the position, which exposes wrong rotation order, a missed wrap, or a stale blank.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;
  localparam int unsigned DIGITS_DEF = 3;
  localparam int unsigned NIBBLE_W   = 4;

  function automatic int unsigned scan_next(int unsigned cur, int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/bcd_scan_pointer.sv
module bcd_scan_pointer #(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mreset_i,
  input  logic             tick_i,
  output logic [POS_W-1:0] pos_o,
  output logic             blank_o
);
  import bcd_scan_pkg::*;

  logic [POS_W-1:0] pos_q, pos_d;
  logic             blank_q, blank_d;
  logic             pos_en;

  assign pos_en = mreset_i | tick_i;

  always_comb begin
    blank_d = mreset_i;
    if (mreset_i) pos_d = '0;
    else          pos_d = POS_W'(scan_next(int'(pos_q), NUM_DIGITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      blank_q <= 1'b1;
    end else begin
      blank_q <= blank_d;
      if (pos_en) pos_q <= pos_d;
    end
  end

  assign pos_o   = pos_q;
  assign blank_o = blank_q;

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) < NUM_DIGITS);
  assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_i |=> (pos_q == '0));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset_i && !tick_i) |=> $stable(pos_q));
  assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreset_i && tick_i) |=>
      (int'(pos_q) == ((int'($past(pos_q)) == NUM_DIGITS - 1) ? 0 : int'($past(pos_q)) + 1)));
endmodule

// File: rtl/bcd_scan_select.sv
module bcd_scan_select #(
  parameter int unsigned NUM_DIGITS = 3,
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mreset_i,
  input  logic [POS_W-1:0]      pos_i,
  input  logic                  blank_i,
  output logic [NUM_DIGITS-1:0] sel_n_o
);
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
    assign sel_n_o[g] = blank_i | (pos_i != POS_W'(g));
  end

  assert_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mreset_i |=> (&sel_n_o));
  assert_one_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_i |-> ($countones(~sel_n_o) == 1));
endmodule

// File: rtl/bcd_scan_datamux.sv
module bcd_scan_datamux #(
  parameter int unsigned NUM_DIGITS = 3,
  parameter int unsigned DIGIT_W    = 4,
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
  input  logic [POS_W-1:0]              pos_i,
  output logic [DIGIT_W-1:0]            bcd_o
);
  always_comb begin
    bcd_o = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (pos_i == POS_W'(i)) bcd_o = digits_i[i*DIGIT_W +: DIGIT_W];
    end
  end
endmodule

// File: rtl/bcd_digit_scanner.sv
module bcd_digit_scanner #(
  parameter int unsigned NUM_DIGITS = bcd_scan_pkg::DIGITS_DEF,
  parameter int unsigned DIGIT_W    = bcd_scan_pkg::NIBBLE_W,
  localparam int unsigned POS_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mreset_i,
  input  logic                          scan_tick_i,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digits_i,
  output logic [DIGIT_W-1:0]            bcd_o,
  output logic [NUM_DIGITS-1:0]         sel_n_o
);
  logic [POS_W-1:0] pos;
  logic             blank;

  bcd_scan_pointer #(.NUM_DIGITS(NUM_DIGITS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .mreset_i(mreset_i), .tick_i(scan_tick_i),
    .pos_o(pos), .blank_o(blank));

  bcd_scan_select #(.NUM_DIGITS(NUM_DIGITS)) u_sel (
    .clk(clk), .rst_n(rst_n), .mreset_i(mreset_i), .pos_i(pos),
    .blank_i(blank), .sel_n_o(sel_n_o));

  bcd_scan_datamux #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) u_mux (
    .digits_i(digits_i), .pos_i(pos), .bcd_o(bcd_o));
endmodule

// File: tb/tb_bcd_digit_scanner.sv
`timescale 1ns/1ps
module tb_bcd_digit_scanner;
  logic        clk = 1'b0;
  logic        rst_n, mreset, tick;
  logic [11:0] digits;
  logic [3:0]  bcd;
  logic [2:0]  sel_n;

  int checks = 0;
  int fails  = 0;
  int m_pos  = 0;
  bit m_blank = 1'b1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_digit_scanner dut (
    .clk(clk), .rst_n(rst_n), .mreset_i(mreset), .scan_tick_i(tick),
    .digits_i(digits), .bcd_o(bcd), .sel_n_o(sel_n));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos   <= 0;
      m_blank <= 1'b1;
    end else begin
      m_blank <= mreset;
      if (mreset)   m_pos <= 0;
      else if (tick) m_pos <= (m_pos == 2) ? 0 : m_pos + 1;
    end
  end

  function automatic logic [2:0] exp_sel(int p, bit b);
    return b ? 3'b111 : ~(3'b001 << p);
  endfunction

  function automatic logic [3:0] exp_bcd(int p, logic [11:0] d);
    return d[p*4 +: 4];
  endfunction

  function automatic logic [11:0] rand_digits();
    logic [11:0] r;
    for (int i = 0; i < 3; i++) r[i*4 +: 4] = 4'($urandom_range(0, 9));
    return r;
  endfunction

  task automatic check(string tag);
    checks++;
    if (sel_n !== exp_sel(m_pos, m_blank) || bcd !== exp_bcd(m_pos, digits)) begin
      fails++;
      $display("FAIL %s: sel_n=%b bcd=%h expected sel_n=%b bcd=%h", tag, sel_n, bcd,
               exp_sel(m_pos, m_blank), exp_bcd(m_pos, digits));
    end
    if (!m_blank) begin
      checks++;
      if ($countones(~sel_n) != 1) begin
        fails++;
        $display("FAIL R7: sel_n=%b expected one low bit", sel_n);
      end
    end
  endtask

  task automatic cyc(bit t, bit m, string tag);
    tick = t; mreset = m;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4553));
    rst_n = 1'b0; mreset = 1'b0; tick = 1'b0;
    digits = 12'h975;
    repeat (3) @(negedge clk);
    check("R1 reset blank");
    rst_n = 1'b1;
    #1 check("R1 before first edge");
    @(negedge clk);
    check("R1 first units after reset");
    // R4 rotation and wrap
    cyc(1, 0, "R4 to tens");
    cyc(1, 0, "R4 to hundreds");
    cyc(1, 0, "R4 wrap to units");
    cyc(1, 0, "R4 to tens again");
    // R5 hold
    cyc(0, 0, "R5 hold");
    cyc(0, 0, "R5 hold");
    // R8 digit change mid-cycle
    digits = 12'h381;
    #1 check("R8 same-cycle digit");
    // R2 R3 R6 master reset with ticks
    cyc(1, 1, "R2 blank");
    cyc(1, 1, "R6 tick ignored in reset");
    cyc(1, 1, "R2 still blank");
    cyc(0, 0, "R3 resume at units");
    cyc(1, 0, "R3 then tens");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      digits = rand_digits();
      cyc(($urandom % 2) == 1, ($urandom % 20) == 0, "R8 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule